// File: doc/BRIEF.md
# Timed Register Pulse and Byte-Scatter Executor

This block runs one 52-bit command at a time against a bank of 32 single-bit output registers and 32 input lines. The command can do one of four things:

- pulse one output high for a programmed number of cycles;
- sample one input after a programmed delay;
- drive eight chosen outputs from the bits of a byte;
- collect eight chosen inputs into a byte.

Both write forms have a deferred variant. It first waits a fixed interval of one second, set by `CLKS_PER_SEC`, before it acts.

The upstream controller presents a command word with `cmd_valid`. The block takes it only while idle, and `busy` covers the whole timed operation. Read results come back on `rd_data` with a one-cycle `rd_valid` strobe. Outputs that a finished write touched go back to 0, so the bank is all-zero whenever the block is idle.

Command fields are as follows:

- The opcode is in bits [51:49].
- The auxiliary count is in bits [43:0].
- For the byte forms, selector k (5 bits) sits at bits [13+5k:9+5k]. Selector 7 therefore overlaps the primary select field [48:44].
- The byte value is in [7:0], and bit 8 is unused.

Top module: `pulse_scatter_exec`

## Requirements
- R1: After reset, `reg_out` is 0, `busy` is 0 and `rd_valid` is 0.
- R2: Opcode 000 raises output `cmd_word[48:44]` in the cycle after acceptance. It holds it for L cycles, where L is the 44-bit count in [43:0], or 1 when that count is 0. `busy` is high for the same L cycles, then the output and `busy` return to 0.
- R3: Opcode 001 keeps `busy` high with all outputs low for `CLKS_PER_SEC` cycles, then behaves as R2.
- R4: Opcode 100 keeps `busy` high for L cycles after acceptance. In the next cycle `rd_valid` is high for one cycle with `rd_data[0]` equal to the selected input and `rd_data[7:1]` equal to 0.
- R5: Opcode 011 sets output `sel_k` to `cmd_word[k]` for k = 0..7, with `sel_k` at [13+5k:9+5k]. This lasts one cycle, during which `busy` is high and all other outputs are 0.
- R6: When two selectors of a byte write name the same output, the bit of the higher-numbered selector is the one driven.
- R7: Opcode 111 waits `CLKS_PER_SEC` cycles with outputs low, then holds the R5 pattern for `CLKS_PER_SEC` cycles, with `busy` high throughout.
- R8: Opcode 010 returns, in the cycle after acceptance, `rd_data[k]` equal to the input named by `sel_k` with `rd_valid` high. `busy` does not rise.
- R9: A `cmd_valid` that arrives while `busy` is high is dropped and does not change the running operation.
- R10: Opcodes 101 and 110 are ignored: outputs, `busy` and `rd_valid` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_word | input | 52 | Command word |
| cmd_valid | input | 1 | Command present this cycle |
| rd_in | input | 32 | Readable input lines |
| reg_out | output | 32 | Output register bank |
| rd_data | output | 8 | Read result |
| rd_valid | output | 1 | One-cycle read result strobe |
| busy | output | 1 | A timed operation is in progress |

## Verification
The bench sweeps every output and input index with hold and delay counts that include 0, where a design that forgot to clamp would wrap to an enormous hold or never finish. Byte writes are tried with all eight selectors naming one register and two opposite value bytes. A design that let the lower selector win would drive the wrong level. A second command is injected in the middle of a timed write. A design that accepted it would show a second output bit or a longer `busy` window. Every cycle of every command is compared against a timeline computed in the bench, so an off-by-one in the one-second wait or the hold length shows up as a mismatch at the window edge.

// File: rtl/exec_pkg.sv
package exec_pkg;
  localparam int CMD_W  = 52;
  localparam int SEL_W  = 5;
  localparam int NREG   = 1 << SEL_W;
  localparam int NSEL   = 8;
  localparam int AUX_W  = 44;
  localparam int SELS_LSB = 9;
  localparam int SELS_W   = NSEL * SEL_W;

  localparam logic [2:0] OP_PULSE        = 3'b000;
  localparam logic [2:0] OP_PULSE_LATE   = 3'b001;
  localparam logic [2:0] OP_GATHER       = 3'b010;
  localparam logic [2:0] OP_SCATTER      = 3'b011;
  localparam logic [2:0] OP_PROBE        = 3'b100;
  localparam logic [2:0] OP_SCATTER_LATE = 3'b111;

  typedef enum logic [1:0] {ST_IDLE, ST_PRE, ST_HOLD, ST_PROBE} exec_state_e;

  function automatic logic [2:0] op_of(input logic [CMD_W-1:0] c);
    return c[CMD_W-1 -: 3];
  endfunction

  function automatic logic [SEL_W-1:0] primary_of(input logic [CMD_W-1:0] c);
    return c[CMD_W-4 -: SEL_W];
  endfunction

  // zero count is treated as a single cycle
  function automatic logic [AUX_W-1:0] hold_len(input logic [CMD_W-1:0] c);
    logic [AUX_W-1:0] a;
    a = c[AUX_W-1:0];
    return (a == '0) ? AUX_W'(1) : a;
  endfunction

  function automatic logic [NREG-1:0] bit_at(input logic [SEL_W-1:0] s);
    return NREG'(1) << s;
  endfunction
endpackage

// File: rtl/exec_countdown.sv
module exec_countdown #(
  parameter int W = 44
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] count,
  output logic         expire
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - W'(1);
  end

  assign count  = cnt_q;
  assign expire = (cnt_q == W'(1));

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - W'(1)));
endmodule

// File: rtl/byte_route.sv
module byte_route #(
  parameter int NREG  = 32,
  parameter int SEL_W = 5,
  parameter int NSEL  = 8
) (
  input  logic [NSEL*SEL_W-1:0] sel_flat,
  input  logic [NSEL-1:0]       value,
  input  logic [NREG-1:0]       lines,
  output logic [NREG-1:0]       pattern,
  output logic [NSEL-1:0]       gathered
);
  // ascending order: a later (higher) selector overwrites an earlier one
  always_comb begin
    pattern = '0;
    for (int k = 0; k < NSEL; k++)
      pattern[sel_flat[k*SEL_W +: SEL_W]] = value[k];
  end

  for (genvar g = 0; g < NSEL; g++) begin : g_gather
    assign gathered[g] = lines[sel_flat[g*SEL_W +: SEL_W]];
  end
endmodule

// File: rtl/pulse_scatter_exec.sv
module pulse_scatter_exec
  import exec_pkg::*;
#(
  parameter int CLKS_PER_SEC = 1_000_000,
  parameter int CNT_W        = AUX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CMD_W-1:0] cmd_word,
  input  logic             cmd_valid,
  input  logic [NREG-1:0]  rd_in,
  output logic [NREG-1:0]  reg_out,
  output logic [NSEL-1:0]  rd_data,
  output logic             rd_valid,
  output logic             busy
);
  localparam logic [CNT_W-1:0] SEC_CNT = CNT_W'(CLKS_PER_SEC);

  exec_state_e      state_q;
  logic [CMD_W-1:0] cmd_q;
  logic [NREG-1:0]  reg_q;
  logic [NSEL-1:0]  rdd_q;
  logic             rdv_q;

  logic             accept;
  logic [2:0]       op_in, op_q;
  logic [CMD_W-1:0] route_cmd;
  logic [NREG-1:0]  pattern;
  logic [NSEL-1:0]  gathered;
  logic             cnt_load, expire;
  logic [CNT_W-1:0] cnt_val, count;

  assign accept    = cmd_valid && (state_q == ST_IDLE);
  assign op_in     = op_of(cmd_word);
  assign op_q      = op_of(cmd_q);
  assign route_cmd = (state_q == ST_IDLE) ? cmd_word : cmd_q;

  byte_route #(.NREG(NREG), .SEL_W(SEL_W), .NSEL(NSEL)) route_i (
    .sel_flat (route_cmd[SELS_LSB +: SELS_W]),
    .value    (route_cmd[NSEL-1:0]),
    .lines    (rd_in),
    .pattern  (pattern),
    .gathered (gathered)
  );

  always_comb begin
    cnt_load = 1'b0;
    cnt_val  = '0;
    if (accept) begin
      unique case (op_in)
        OP_PULSE, OP_PROBE:             begin cnt_load = 1'b1; cnt_val = CNT_W'(hold_len(cmd_word)); end
        OP_PULSE_LATE, OP_SCATTER_LATE: begin cnt_load = 1'b1; cnt_val = SEC_CNT; end
        OP_SCATTER:                     begin cnt_load = 1'b1; cnt_val = CNT_W'(1); end
        default: ;
      endcase
    end else if (state_q == ST_PRE && expire) begin
      cnt_load = 1'b1;
      cnt_val  = (op_q == OP_PULSE_LATE) ? CNT_W'(hold_len(cmd_q)) : SEC_CNT;
    end
  end

  exec_countdown #(.W(CNT_W)) timer_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cnt_load),
    .load_val (cnt_val),
    .count    (count),
    .expire   (expire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cmd_q   <= '0;
      reg_q   <= '0;
      rdd_q   <= '0;
      rdv_q   <= 1'b0;
    end else begin
      rdv_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          cmd_q <= cmd_word;
          unique case (op_in)
            OP_PULSE:   begin reg_q <= bit_at(primary_of(cmd_word)); state_q <= ST_HOLD; end
            OP_SCATTER: begin reg_q <= pattern; state_q <= ST_HOLD; end
            OP_PULSE_LATE, OP_SCATTER_LATE: state_q <= ST_PRE;
            OP_PROBE:   state_q <= ST_PROBE;
            OP_GATHER:  begin rdd_q <= gathered; rdv_q <= 1'b1; end
            default: ;
          endcase
        end
        ST_PRE: if (expire) begin
          reg_q   <= (op_q == OP_PULSE_LATE) ? bit_at(primary_of(cmd_q)) : pattern;
          state_q <= ST_HOLD;
        end
        ST_HOLD: if (expire) begin
          reg_q   <= '0;
          state_q <= ST_IDLE;
        end
        ST_PROBE: if (expire) begin
          rdd_q   <= NSEL'(rd_in[primary_of(cmd_q)]);
          rdv_q   <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign reg_out  = reg_q;
  assign rd_data  = rdd_q;
  assign rd_valid = rdv_q;
  assign busy     = (state_q != ST_IDLE);

  // R2
  pulse_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HOLD && (op_q == OP_PULSE || op_q == OP_PULSE_LATE)) |-> ($countones(reg_out) == 1));
  // R3
  prewait_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PRE) |-> (reg_out == '0));
  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HOLD && !expire) |=> $stable(reg_out));
  // R10
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (reg_out == '0));
  // R4
  probe_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PROBE && expire) |=> (rd_valid && rd_data[NSEL-1:1] == '0));
endmodule

// File: tb/pulse_scatter_exec_tb_top.sv
module pulse_scatter_exec_tb_top;
  localparam int CPS = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [51:0] cmd_word = '0;
  logic        cmd_valid = 1'b0;
  logic [31:0] rd_in = '0;
  logic [31:0] reg_out;
  logic [7:0]  rd_data;
  logic        rd_valid, busy;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  pulse_scatter_exec #(.CLKS_PER_SEC(CPS)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_word(cmd_word), .cmd_valid(cmd_valid),
    .rd_in(rd_in), .reg_out(reg_out), .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy)
  );

  function automatic logic [51:0] mk_one(input logic [2:0] op, input logic [4:0] r, input logic [43:0] aux);
    return {op, r, aux};
  endfunction

  function automatic logic [51:0] mk_byte(input logic [2:0] op, input logic [39:0] sels, input logic [7:0] v);
    return {op, sels, 1'b0, v};
  endfunction

  // reverse walk: first claim from the top selector is final
  function automatic logic [31:0] ref_scatter(input logic [51:0] c);
    logic [31:0] p = '0, taken = '0;
    for (int k = 7; k >= 0; k--) begin
      int s = int'(c[9 + 5*k +: 5]);
      if (!taken[s]) begin
        taken[s] = 1'b1;
        p[s] = c[k];
      end
    end
    return p;
  endfunction

  function automatic logic [7:0] ref_gather(input logic [51:0] c, input logic [31:0] lines);
    logic [7:0] g;
    for (int k = 0; k < 8; k++) g[k] = lines[int'(c[9 + 5*k +: 5])];
    return g;
  endfunction

  task automatic check(input string tag, input logic [31:0] eo, input logic eb,
                       input logic erv, input logic [7:0] ed);
    checks++;
    if (reg_out !== eo || busy !== eb || rd_valid !== erv || (erv && rd_data !== ed)) begin
      errors++;
      $display("FAIL %s: out=%h busy=%b rv=%b data=%h expected out=%h busy=%b rv=%b data=%h",
               tag, reg_out, busy, rd_valid, rd_data, eo, eb, erv, ed);
    end
  endtask

  task automatic run(input logic [51:0] c, input string tag, input bit drop);
    logic [2:0]  op = c[51:49];
    int          sel = int'(c[48:44]);
    int          len = (c[43:0] == 0) ? 1 : int'(c[43:0]);
    int          pre = 0, act = 0, total;
    logic [31:0] patt = '0;
    if (op == 3'b001 || op == 3'b111) pre = CPS;
    if (op == 3'b000 || op == 3'b001) begin act = len; patt = 32'd1 << sel; end
    if (op == 3'b011) begin act = 1; patt = ref_scatter(c); end
    if (op == 3'b111) begin act = CPS; patt = ref_scatter(c); end
    total = (op == 3'b100) ? len + 2 : pre + act + 2;
    @(negedge clk);
    cmd_word  = c;
    cmd_valid = 1'b1;
    for (int i = 1; i <= total; i++) begin
      logic [31:0] eo = '0;
      logic eb = 1'b0, erv = 1'b0;
      logic [7:0] ed = '0;
      @(negedge clk);
      case (op)
        3'b000, 3'b001, 3'b011, 3'b111: begin
          eb = (i <= pre + act);
          if (i > pre && i <= pre + act) eo = patt;
        end
        3'b100: begin
          eb  = (i <= len);
          erv = (i == len + 1);
          ed  = {7'b0, rd_in[sel]};
        end
        3'b010: begin
          erv = (i == 1);
          ed  = ref_gather(c, rd_in);
        end
        default: ;
      endcase
      check(tag, eo, eb, erv, ed);
      if (drop && i == 1) begin
        cmd_word = mk_one(3'b000, 5'(sel + 1), 44'd20);
      end else begin
        cmd_valid = 1'b0;
      end
    end
    cmd_valid = 1'b0;
  endtask

  initial begin
    #600000;
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", '0, 1'b0, 1'b0, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", '0, 1'b0, 1'b0, '0);

    for (int r = 0; r < 32; r++) run(mk_one(3'b000, 5'(r), 44'(r % 4)), "R2 pulse", 1'b0);
    run(mk_one(3'b000, 5'd7, 44'd12), "R2 long pulse", 1'b0);
    run(mk_one(3'b001, 5'd5, 44'd3), "R3 late pulse", 1'b0);
    run(mk_one(3'b001, 5'd31, 44'd0), "R3 late pulse zero", 1'b0);

    rd_in = 32'hA5C3_1E69;
    for (int r = 0; r < 32; r++) run(mk_one(3'b100, 5'(r), 44'((r % 3) + 1)), "R4 probe", 1'b0);
    rd_in = ~rd_in;
    run(mk_one(3'b100, 5'd0, 44'd0), "R4 probe zero", 1'b0);
    run(mk_one(3'b100, 5'd17, 44'd5), "R4 probe", 1'b0);

    run(mk_byte(3'b011, {5'd31, 5'd24, 5'd20, 5'd13, 5'd9, 5'd6, 5'd2, 5'd0}, 8'hA5), "R5 scatter", 1'b0);
    run(mk_byte(3'b011, {5'd1, 5'd3, 5'd5, 5'd7, 5'd11, 5'd19, 5'd23, 5'd29}, 8'h3C), "R5 scatter", 1'b0);
    run(mk_byte(3'b011, {5'd8, 5'd9, 5'd10, 5'd11, 5'd12, 5'd13, 5'd14, 5'd15}, 8'hFF), "R5 scatter", 1'b0);
    run(mk_byte(3'b011, {8{5'd9}}, 8'h80), "R6 duplicate high one", 1'b0);
    run(mk_byte(3'b011, {8{5'd9}}, 8'h7F), "R6 duplicate high zero", 1'b0);
    run(mk_byte(3'b011, {5'd4, 5'd4, 5'd2, 5'd2, 5'd1, 5'd1, 5'd0, 5'd0}, 8'h55), "R6 duplicate pairs", 1'b0);

    run(mk_byte(3'b111, {5'd30, 5'd25, 5'd18, 5'd12, 5'd8, 5'd4, 5'd3, 5'd1}, 8'hC6), "R7 late scatter", 1'b0);

    rd_in = 32'h0F0F_3355;
    run(mk_byte(3'b010, {5'd31, 5'd24, 5'd20, 5'd13, 5'd9, 5'd6, 5'd2, 5'd0}, 8'h00), "R8 gather", 1'b0);
    run(mk_byte(3'b010, {5'd0, 5'd1, 5'd2, 5'd3, 5'd4, 5'd5, 5'd6, 5'd7}, 8'h00), "R8 gather", 1'b0);
    rd_in = 32'hDEAD_BEEF;
    run(mk_byte(3'b010, {5'd28, 5'd16, 5'd16, 5'd9, 5'd5, 5'd27, 5'd14, 5'd30}, 8'h00), "R8 gather", 1'b0);

    run(mk_one(3'b000, 5'd3, 44'd6), "R9 drop during pulse", 1'b1);
    run(mk_one(3'b001, 5'd10, 44'd2), "R9 drop during wait", 1'b1);

    run(mk_one(3'b101, 5'd6, 44'd4), "R10 opcode 101", 1'b0);
    run(mk_byte(3'b110, {8{5'd2}}, 8'hFF), "R10 opcode 110", 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule